// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupts

This block drives and samples a parameterised group of general-purpose pins, up to 31, from a 32-bit word-addressed register bus. Each pin has a direction bit, a synchronised input level, and an output latch. The latch is changed only by write-one-to-set and write-one-to-clear words, so two agents can update different pins without a read-modify-write race. A build-time switch flips the sense of the direction word, for integrations whose pad cells expect an active-low input select.

Every pin can also raise an interrupt. Per pin, software picks level or edge sensitivity and the active polarity, turns detection on with an enable bit, and gates delivery with a separate mask bit. Edge events latch into a sticky pending bit that software clears by writing a one. Level conditions are shown live in the pending word. A single output is raised while any pending pin is also unmasked. Software builds a both-edges trigger by flipping the polarity after each event.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_out` and `irq_out` are 0, and `pin_oe` is 0 in the normal variant.
- R2: Writing the set word (byte offset 0x0C) sets each output latch bit written as 1. Writing the clear word (0x10) clears each latch bit written as 1. Bits written as 0 are unchanged. Both words read back the current latch value, which drives `pin_out`.
- R3: The direction word (0x00) drives `pin_oe` directly when `INV_DIR` is 0, and inverted when `INV_DIR` is 1. In both cases `pin_oe` changes on the clock after the write.
- R4: Bits at or above `PIN_COUNT` read as zero in every word, and writes to them are ignored.
- R5: The input word (0x04) returns each pin's level two clocks after it changes at `pin_in`, whatever the pin's direction. Writes to it are ignored.
- R6: With type bit 0 (edge, word 0x18) the polarity bit (word 0x1C) selects a rising edge (1) or a falling edge (0). A matching edge sets the pending bit (word 0x20) only while the enable bit (word 0x14) is 1. The pending bit then holds until a 1 is written to it. Writing 0 has no effect.
- R7: An edge detected in the same cycle as a clear write to that pending bit leaves the bit set.
- R8: With type bit 1 (level) the pending bit is 1 one clock after the synchronised level equals the polarity bit while enabled, and 0 otherwise. Writes to it are ignored.
- R9: Clearing a pin's enable bit clears its pending bit on the next clock.
- R10: `irq_out` is 1 exactly when some pin is both pending and has its mask bit (word 0x24) set to 1.
- R11: `bus_rdata` loads the addressed word on the clock edge where `bus_rd` is 1, and holds its value otherwise. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the word accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output latch |
| pin_oe | output | PIN_COUNT | Drive enable per pin, 1 = drive |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong pending cell shows at the ports within one clock: `irq_out` rises or falls against the mask, or the next pending read disagrees with the edge history the bench has applied. A lost or phantom edge stays visible in the sticky bit until software clears it. A fault in the synchroniser shifts every input and pending change by a clock, so checks are taken at fixed cycle counts after each pin change. A wrong latch or direction value appears on `pin_out` or `pin_oe` on the clock after the bus write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned BUS_W = 32;

  typedef enum logic [3:0] {
    SEL_DIR, SEL_LVL, SEL_SET, SEL_CLR, SEL_IEN,
    SEL_TYP, SEL_POL, SEL_PND, SEL_MSK, SEL_NONE
  } reg_sel_e;

  // Word offsets are the software contract; anything else is unmapped.
  function automatic reg_sel_e decode_sel(input logic [BUS_W-1:0] off);
    case (off)
      32'h00:  return SEL_DIR;
      32'h04:  return SEL_LVL;
      32'h0C:  return SEL_SET;
      32'h10:  return SEL_CLR;
      32'h14:  return SEL_IEN;
      32'h18:  return SEL_TYP;
      32'h1C:  return SEL_POL;
      32'h20:  return SEL_PND;
      32'h24:  return SEL_MSK;
      default: return SEL_NONE;
    endcase
  endfunction

  // Transition between two successive samples, direction chosen by pol.
  function automatic logic edge_hit(input logic cur, input logic prv, input logic pol);
    return pol ? (cur & ~prv) : (~cur & prv);
  endfunction

  // Level condition: sample equals the chosen active level.
  function automatic logic level_hit(input logic cur, input logic pol);
    return cur == pol;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] prev_q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  p_prev_trails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev_q == $past(sync_q));
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl_mode,
  input  logic pol,
  input  logic cur,
  input  logic prv,
  input  logic clr,
  output logic pend
);
  logic edge_evt;
  logic lvl_evt;

  assign edge_evt = edge_hit(cur, prv, pol);
  assign lvl_evt  = level_hit(cur, pol);

  always_ff @(posedge clk) begin
    if (!rst_n)        pend <= 1'b0;
    else if (!en)      pend <= 1'b0;
    else if (lvl_mode) pend <= lvl_evt;
    else if (edge_evt) pend <= 1'b1;
    else if (clr)      pend <= 1'b0;
  end

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pend);
  p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !lvl_mode && edge_evt) |=> pend);
  p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !lvl_mode && pend && !clr) |=> pend);
  p_level_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && lvl_mode) |=> pend == $past(cur == pol));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 8,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_rd,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [PIN_COUNT-1:0] lvl_in,
  input  logic [PIN_COUNT-1:0] pend_in,
  output logic [PIN_COUNT-1:0] dir_q,
  output logic [PIN_COUNT-1:0] out_q,
  output logic [PIN_COUNT-1:0] ien_q,
  output logic [PIN_COUNT-1:0] typ_q,
  output logic [PIN_COUNT-1:0] pol_q,
  output logic [PIN_COUNT-1:0] msk_q,
  output logic [PIN_COUNT-1:0] pend_clr
);
  reg_sel_e             sel;
  logic [PIN_COUNT-1:0] wbits;
  logic [BUS_W-1:0]     rd_word;

  assign sel      = decode_sel(BUS_W'(bus_addr));
  assign wbits    = bus_wdata[PIN_COUNT-1:0];
  assign pend_clr = (bus_wr && sel == SEL_PND) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
      typ_q <= '0;
      pol_q <= '0;
      msk_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DIR: dir_q <= wbits;
        SEL_SET: out_q <= out_q | wbits;
        SEL_CLR: out_q <= out_q & ~wbits;
        SEL_IEN: ien_q <= wbits;
        SEL_TYP: typ_q <= wbits;
        SEL_POL: pol_q <= wbits;
        SEL_MSK: msk_q <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DIR:          rd_word = BUS_W'(dir_q);
      SEL_LVL:          rd_word = BUS_W'(lvl_in);
      SEL_SET, SEL_CLR: rd_word = BUS_W'(out_q);
      SEL_IEN:          rd_word = BUS_W'(ien_q);
      SEL_TYP:          rd_word = BUS_W'(typ_q);
      SEL_POL:          rd_word = BUS_W'(pol_q);
      SEL_PND:          rd_word = BUS_W'(pend_in);
      SEL_MSK:          rd_word = BUS_W'(msk_q);
      default:          rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  p_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_SET) |=> (out_q & $past(wbits)) == $past(wbits));
  p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CLR) |=> (out_q & $past(wbits)) == '0);
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata >> PIN_COUNT) == '0);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter bit          INV_DIR   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic                 irq_out
);
  logic [PIN_COUNT-1:0] sync_v, prev_v, pend_v, clr_v;
  logic [PIN_COUNT-1:0] dir_v, out_v, ien_v, typ_v, pol_v, msk_v;

  gpio_in_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_q(sync_v), .prev_q(prev_v)
  );

  gpio_regfile #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .lvl_in(sync_v), .pend_in(pend_v), .dir_q(dir_v), .out_q(out_v),
    .ien_q(ien_v), .typ_q(typ_v), .pol_q(pol_v), .msk_q(msk_v), .pend_clr(clr_v)
  );

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    gpio_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n), .en(ien_v[i]), .lvl_mode(typ_v[i]),
      .pol(pol_v[i]), .cur(sync_v[i]), .prv(prev_v[i]), .clr(clr_v[i]),
      .pend(pend_v[i])
    );
  end

  if (INV_DIR) begin : g_dir_inv
    assign pin_oe = ~dir_v;
  end else begin : g_dir_norm
    assign pin_oe = dir_v;
  end

  assign pin_out = out_v;
  assign irq_out = |(pend_v & msk_v);

  p_oe_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && decode_sel(32'(bus_addr)) == SEL_DIR) |=>
      pin_oe == (INV_DIR ? ~$past(bus_wdata[PIN_COUNT-1:0]) : $past(bus_wdata[PIN_COUNT-1:0])));
  p_irq_needs_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_v != '0) && (msk_v != '0));
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  localparam int unsigned N      = 8;
  localparam time         CLK_PER = 10ns;

  localparam logic [7:0] A_DIR = 8'h00, A_LVL = 8'h04, A_SET = 8'h0C, A_CLR = 8'h10,
                         A_IEN = 8'h14, A_TYP = 8'h18, A_POL = 8'h1C, A_PND = 8'h20,
                         A_MSK = 8'h24;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PIN = 2'd2, OP_IRQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  A_DIR, 32'h0,         4'd1},   // R1 reset
    '{OP_RD,  A_PND, 32'h0,         4'd1},   // R1
    '{OP_WR,  A_SET, 32'h0000_01A5, 4'd2},   // R2, bit 8 beyond pins
    '{OP_RD,  A_SET, 32'h0000_00A5, 4'd4},   // R4
    '{OP_WR,  A_CLR, 32'h0000_0021, 4'd2},
    '{OP_RD,  A_CLR, 32'h0000_0084, 4'd2},   // R2
    '{OP_WR,  A_SET, 32'h0,         4'd2},
    '{OP_RD,  A_SET, 32'h0000_0084, 4'd2},   // R2 zeros no effect
    '{OP_WR,  A_DIR, 32'hFFFF_FF0F, 4'd4},
    '{OP_RD,  A_DIR, 32'h0000_000F, 4'd4},   // R4
    '{OP_PIN, 8'h00, 32'h0000_005A, 4'd5},
    '{OP_RD,  A_LVL, 32'h0000_005A, 4'd5},   // R5
    '{OP_WR,  A_LVL, 32'h0000_00FF, 4'd5},
    '{OP_RD,  A_LVL, 32'h0000_005A, 4'd5},   // R5 read-only
    '{OP_WR,  A_POL, 32'h0000_0001, 4'd6},
    '{OP_WR,  A_IEN, 32'h0000_0003, 4'd6},
    '{OP_WR,  A_MSK, 32'h0000_0001, 4'd10},
    '{OP_RD,  A_PND, 32'h0,         4'd6},
    '{OP_IRQ, 8'h00, 32'h0,         4'd10},
    '{OP_PIN, 8'h00, 32'h0000_005B, 4'd6},   // bit0 rises
    '{OP_RD,  A_PND, 32'h0000_0001, 4'd6},   // R6
    '{OP_IRQ, 8'h00, 32'h1,         4'd10},  // R10
    '{OP_PIN, 8'h00, 32'h0000_0059, 4'd6},   // bit1 falls
    '{OP_RD,  A_PND, 32'h0000_0003, 4'd6},
    '{OP_PIN, 8'h00, 32'h0000_0058, 4'd6},   // bit0 falls, not armed
    '{OP_WR,  A_PND, 32'h0,         4'd6},
    '{OP_RD,  A_PND, 32'h0000_0003, 4'd6},   // R6 sticky
    '{OP_WR,  A_PND, 32'h0000_0001, 4'd6},
    '{OP_RD,  A_PND, 32'h0000_0002, 4'd6},
    '{OP_IRQ, 8'h00, 32'h0,         4'd10},  // R10 masked
    '{OP_WR,  A_MSK, 32'h0000_0002, 4'd10},
    '{OP_IRQ, 8'h00, 32'h1,         4'd10},
    '{OP_WR,  A_IEN, 32'h0000_0001, 4'd9},
    '{OP_RD,  A_PND, 32'h0,         4'd9},   // R9
    '{OP_PIN, 8'h00, 32'h0000_005A, 4'd6},
    '{OP_PIN, 8'h00, 32'h0000_0058, 4'd6},   // bit1 falls while off
    '{OP_WR,  A_IEN, 32'h0000_0003, 4'd6},
    '{OP_RD,  A_PND, 32'h0,         4'd6},
    '{OP_WR,  A_TYP, 32'h0000_0010, 4'd8},
    '{OP_WR,  A_POL, 32'h0000_0011, 4'd8},
    '{OP_WR,  A_IEN, 32'h0000_0013, 4'd8},
    '{OP_RD,  A_PND, 32'h0000_0010, 4'd8},   // R8
    '{OP_WR,  A_PND, 32'h0000_0010, 4'd8},
    '{OP_RD,  A_PND, 32'h0000_0010, 4'd8},   // R8 ignores clear
    '{OP_PIN, 8'h00, 32'h0000_0048, 4'd8},
    '{OP_RD,  A_PND, 32'h0,         4'd8}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata, inv_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe, inv_out, inv_oe;
  logic          irq_out, inv_irq;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  gpio_irq_ctrl #(.PIN_COUNT(N), .ADDR_W(8), .INV_DIR(1'b0)) i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  gpio_irq_ctrl #(.PIN_COUNT(N), .ADDR_W(8), .INV_DIR(1'b1)) i_inv (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(inv_rdata),
    .pin_in('0), .pin_out(inv_out), .pin_oe(inv_oe), .irq_out(inv_irq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports; R3 inverted variant drives all pins
    check(1, 32'(pin_oe), 32'h0, "pin_oe after reset");
    check(1, 32'(pin_out), 32'h0, "pin_out after reset");
    check(1, 32'(irq_out), 32'h0, "irq_out after reset");
    check(3, 32'(inv_oe), 32'h0000_00FF, "inverted pin_oe after reset");

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:  bus_write(VECS[i].addr, VECS[i].data);
        OP_RD: begin
          bus_read(VECS[i].addr, rd);
          check(int'(VECS[i].req), rd, VECS[i].data, $sformatf("vector %0d read", i));
        end
        OP_PIN: begin
          @(negedge clk);
          pin_in = VECS[i].data[N-1:0];
          repeat (4) @(negedge clk);
        end
        default: begin
          @(negedge clk);
          check(int'(VECS[i].req), 32'(irq_out), VECS[i].data, $sformatf("vector %0d irq", i));
        end
      endcase
    end

    // R3 direction word as seen on both variants, R2 latch on pin_out
    check(3, 32'(pin_oe), 32'h0000_000F, "pin_oe normal");
    check(3, 32'(inv_oe), 32'h0000_00F0, "pin_oe inverted");
    check(2, 32'(pin_out), 32'h0000_0084, "pin_out latch");

    // R10 level source through mask
    bus_write(A_MSK, 32'h10);
    @(negedge clk);
    check(10, 32'(irq_out), 32'h0, "level low, masked in");
    @(negedge clk); pin_in = 8'h58;
    repeat (4) @(negedge clk);
    check(10, 32'(irq_out), 32'h1, "level high raises irq");
    bus_write(A_IEN, 32'h03);
    @(negedge clk);
    check(9, 32'(irq_out), 32'h0, "disable drops irq");

    // R7 edge in the cycle of the clear write keeps the bit
    bus_write(A_TYP, 32'h0);
    bus_write(A_POL, 32'h01);
    bus_write(A_IEN, 32'h01);
    @(negedge clk); pin_in = 8'h59;
    repeat (4) @(negedge clk);
    @(negedge clk); pin_in = 8'h58;
    repeat (4) @(negedge clk);
    bus_read(A_PND, rd);
    check(6, rd, 32'h1, "rising edge captured");
    @(negedge clk); pin_in = 8'h59;
    @(negedge clk);
    bus_write(A_PND, 32'h1);
    bus_read(A_PND, rd);
    check(7, rd, 32'h1, "edge wins over same-cycle clear");
    bus_write(A_PND, 32'h1);
    bus_read(A_PND, rd);
    check(7, rd, 32'h0, "later clear succeeds");

    // R11 read data holds without a strobe; unmapped reads zero
    bus_read(A_DIR, held);
    @(negedge clk); bus_addr = A_SET;
    repeat (2) @(negedge clk);
    check(11, bus_rdata, held, "rdata held");
    bus_read(8'h08, rd);
    check(11, rd, 32'h0, "unmapped offset");

    finish_run();
  end
endmodule